// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block is a single up-counting timer channel that produces exactly one output pulse for each qualifying edge on a trigger input. While idle the counter rests at zero. A trigger edge of the selected direction starts it. The output reference takes its active level once the count reaches the compare value. The counter keeps running up to the auto-reload value, then wraps to zero and stops by itself. That wrap is an update event: it returns the reference to its idle level and raises a one-cycle update flag.

The compare and reload values each have a shadow register. When preload is enabled for a value, a write lands only in its shadow. The active copy then changes on an update event: either the software update strobe or the end-of-pulse wrap. When preload is disabled, a write reaches the active copy at once.

A fast-enable option forces the reference to its matched level on the clock edge that starts the counter, so the pulse does not wait for the first comparison. An output polarity bit inverts the final pin level.

Top module: `opc_one_pulse`

## Requirements
- R1: While reset is asserted, the counter is stopped at zero, the reference is low, `upd_flag` is 0 and `pulse_out` equals `out_inv`.
- R2: With `trig_fall`=0 only a rising edge of `trig_in` starts the counter, and with `trig_fall`=1 only a falling edge does. The opposite edge leaves the output and flag unchanged.
- R3: In mode 3'b111 (PWM2) the reference rises exactly CMP clock edges after the edge at which the new trigger level is first sampled (the count then equals CMP), for CMP ≥ 1.
- R4: The reference falls on the edge after the count equals ARL, when the counter wraps to 0 and stops, so it is high for ARL−CMP+1 cycles. No further pulse occurs without another trigger.
- R5: A trigger edge that arrives while the counter is running is ignored, and the pulse timing is unchanged.
- R6: `upd_flag` is high for exactly one cycle after each wrap from ARL to 0 and after each `upd_strobe` cycle. It is high at no other time.
- R7: In mode 3'b110 (PWM1) the reference is high while the count is below CMP and low otherwise, giving the inverse of the PWM2 waveform.
- R8: With `fast_en`=1 in PWM1 or PWM2, the reference takes its matched level (PWM2: 1, PWM1: 0) on the same edge that starts the counter. It keeps that level until the wrap.
- R9: In any mode code other than 3'b110 and 3'b111 the reference stays low, `fast_en` has no effect, and the counter still runs and wraps.
- R10: `out_inv`=1 inverts `pulse_out` relative to the reference.
- R11: With a preload bit set, a write goes only to the shadow copy, and `upd_strobe` moves the shadow into the active copy. With the bit clear, a write takes effect on the next edge.
- R12: The wrap at the end of a pulse also moves both shadows into the active copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Trigger input |
| trig_fall | input | 1 | Trigger edge select: 0 rising, 1 falling |
| out_inv | input | 1 | Output polarity: 1 inverts the pin |
| mode | input | 3 | Channel mode: 3'b110 PWM1, 3'b111 PWM2, others keep the reference low |
| fast_en | input | 1 | Force the matched level on the trigger |
| cmp_val | input | CNT_W | Compare write data |
| cmp_we | input | 1 | Compare write strobe |
| cmp_pre | input | 1 | Compare preload enable |
| arl_val | input | CNT_W | Auto-reload write data |
| arl_we | input | 1 | Auto-reload write strobe |
| arl_pre | input | 1 | Auto-reload preload enable |
| upd_strobe | input | 1 | Software update request |
| pulse_out | output | 1 | Pulse output after polarity |
| upd_flag | output | 1 | One-cycle update event flag |

## Verification
On every cycle the assertions check the counter's internal behaviour:
- it rests at zero when stopped;
- it advances by one while running, so retriggers never restart it;
- it stops and flags on the wrap;
- in PWM2 the reference tracks the comparison, and the fast path forces it high;
- in non-PWM modes the reference stays low;
- every flag has a legal cause.

Only the bench scenarios can show the behaviour seen at the pins:
- the cycle-exact rise and fall positions for several compare and reload pairs;
- edge-select filtering and the PWM1 and polarity inversions;
- that preloaded values take effect only after a strobe or a completed pulse.

// File: rtl/opc_pkg.sv
package opc_pkg;
    localparam logic [2:0] OPC_MODE_PWM1 = 3'b110;
    localparam logic [2:0] OPC_MODE_PWM2 = 3'b111;

    function automatic logic opc_is_pwm(input logic [2:0] m);
        return m[2:1] == 2'b11;
    endfunction
endpackage

// File: rtl/opc_edge_det.sv
module opc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic fall_sel,
    output logic hit
);
    typedef struct packed {
        logic prev;
    } ed_st_t;

    ed_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig;
        hit       = fall_sel ? (st_q.prev & ~sig) : (~st_q.prev & sig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/opc_preload_reg.sv
module opc_preload_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         pre_en,
    input  logic         load,
    input  logic [W-1:0] wval,
    output logic [W-1:0] act
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } pr_st_t;

    pr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.active = st_q.shadow;
        if (we) begin
            st_d.shadow = wval;
            if (!pre_en) st_d.active = wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.active;
endmodule

// File: rtl/opc_counter.sv
module opc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         fast_arm,
    input  logic [W-1:0] arl,
    output logic         start,
    output logic         wrap,
    output logic         run_q,
    output logic         fast_q,
    output logic [W-1:0] cnt_q,
    output logic         fast_nxt,
    output logic [W-1:0] cnt_nxt
);
    typedef struct packed {
        logic         run;
        logic         fast;
        logic [W-1:0] cnt;
    } ct_st_t;

    ct_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = start_req & ~st_q.run;
        wrap  = st_q.run & (st_q.cnt == arl);
        if (st_q.run) begin
            if (wrap) begin
                st_d.cnt  = '0;
                st_d.run  = 1'b0;
                st_d.fast = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.run  = 1'b1;
            st_d.cnt  = '0;
            st_d.fast = fast_arm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_q    = st_q.run;
    assign fast_q   = st_q.fast;
    assign cnt_q    = st_q.cnt;
    assign fast_nxt = st_d.fast;
    assign cnt_nxt  = st_d.cnt;
endmodule

// File: rtl/opc_ref_gen.sv
module opc_ref_gen
    import opc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         force_match,
    output logic         ref_lvl
);
    logic matched;

    always_comb begin
        matched = force_match | (cnt >= cmp);
        case (mode)
            OPC_MODE_PWM2: ref_lvl = matched;
            OPC_MODE_PWM1: ref_lvl = ~matched;
            default:       ref_lvl = 1'b0;
        endcase
    end
endmodule

// File: rtl/opc_one_pulse.sv
module opc_one_pulse
    import opc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             trig_fall,
    input  logic             out_inv,
    input  logic [2:0]       mode,
    input  logic             fast_en,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_we,
    input  logic             cmp_pre,
    input  logic [CNT_W-1:0] arl_val,
    input  logic             arl_we,
    input  logic             arl_pre,
    input  logic             upd_strobe,
    output logic             pulse_out,
    output logic             upd_flag
);
    localparam int NREG    = 2;
    localparam int IDX_CMP = 0;
    localparam int IDX_ARL = 1;

    typedef struct packed {
        logic refl;
        logic flag;
    } out_st_t;

    out_st_t out_d, out_q;

    logic                       trig_hit;
    logic                       start, wrap, run_q, fast_q, fast_nxt;
    logic [CNT_W-1:0]           cnt_q, cnt_nxt;
    logic [CNT_W-1:0]           cmp_act, arl_act;
    logic                       upd_evt, ref_nxt, ref_q;
    logic [NREG-1:0][CNT_W-1:0] pr_wval, pr_act;
    logic [NREG-1:0]            pr_we, pr_pre;

    opc_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (trig_in),
        .fall_sel (trig_fall),
        .hit      (trig_hit)
    );

    assign upd_evt = upd_strobe | wrap;

    assign pr_wval[IDX_CMP] = cmp_val;
    assign pr_we[IDX_CMP]   = cmp_we;
    assign pr_pre[IDX_CMP]  = cmp_pre;
    assign pr_wval[IDX_ARL] = arl_val;
    assign pr_we[IDX_ARL]   = arl_we;
    assign pr_pre[IDX_ARL]  = arl_pre;

    for (genvar g = 0; g < NREG; g++) begin : g_preload
        opc_preload_reg #(.W(CNT_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (pr_we[g]),
            .pre_en (pr_pre[g]),
            .load   (upd_evt),
            .wval   (pr_wval[g]),
            .act    (pr_act[g])
        );
    end

    assign cmp_act = pr_act[IDX_CMP];
    assign arl_act = pr_act[IDX_ARL];

    opc_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (trig_hit),
        .fast_arm  (fast_en & opc_is_pwm(mode)),
        .arl       (arl_act),
        .start     (start),
        .wrap      (wrap),
        .run_q     (run_q),
        .fast_q    (fast_q),
        .cnt_q     (cnt_q),
        .fast_nxt  (fast_nxt),
        .cnt_nxt   (cnt_nxt)
    );

    opc_ref_gen #(.W(CNT_W)) u_ref (
        .mode        (mode),
        .cnt         (cnt_nxt),
        .cmp         (cmp_act),
        .force_match (fast_nxt),
        .ref_lvl     (ref_nxt)
    );

    always_comb begin
        out_d      = out_q;
        out_d.refl = ref_nxt;
        out_d.flag = upd_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ref_q     = out_q.refl;
    assign pulse_out = out_q.refl ^ out_inv;
    assign upd_flag  = out_q.flag;
endmodule

// File: rtl/opc_checker.sv
module opc_checker
    import opc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   mode,
    input logic         fast_en,
    input logic         upd_strobe,
    input logic         start,
    input logic         run_q,
    input logic         fast_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cmp_act,
    input logic [W-1:0] arl_act,
    input logic         ref_q,
    input logic         upd_flag
);
    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> cnt_q == '0); // R4

    AST_STEP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != arl_act) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1)); // R5

    AST_STOP_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == arl_act) |=> (!run_q && upd_flag)); // R4

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_flag |-> $past(upd_strobe || (run_q && cnt_q == arl_act))); // R6

    AST_PWM2_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != arl_act && mode == OPC_MODE_PWM2 && !fast_q)
        |=> (ref_q == (cnt_q >= $past(cmp_act)))); // R3

    AST_FAST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && fast_en && mode == OPC_MODE_PWM2) |=> ref_q); // R8

    AST_NONPWM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[2:1] != 2'b11) |=> !ref_q); // R9
endmodule

bind opc_one_pulse opc_checker #(.W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .fast_en    (fast_en),
    .upd_strobe (upd_strobe),
    .start      (start),
    .run_q      (run_q),
    .fast_q     (fast_q),
    .cnt_q      (cnt_q),
    .cmp_act    (cmp_act),
    .arl_act    (arl_act),
    .ref_q      (ref_q),
    .upd_flag   (upd_flag)
);

// File: tb/opc_one_pulse_tb.sv
module opc_one_pulse_tb_top;
    localparam int CLK_P = 10;
    localparam int W     = 16;
    localparam int WIN   = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig_in = 1'b0, trig_fall = 1'b0, out_inv = 1'b0;
    logic [2:0]   mode = 3'b111;
    logic         fast_en = 1'b0;
    logic [W-1:0] cmp_val = '0, arl_val = '0;
    logic         cmp_we = 1'b0, arl_we = 1'b0, cmp_pre = 1'b0, arl_pre = 1'b0;
    logic         upd_strobe = 1'b0;
    logic         pulse_out, upd_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    opc_one_pulse #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_fall(trig_fall),
        .out_inv(out_inv), .mode(mode), .fast_en(fast_en),
        .cmp_val(cmp_val), .cmp_we(cmp_we), .cmp_pre(cmp_pre),
        .arl_val(arl_val), .arl_we(arl_we), .arl_pre(arl_pre),
        .upd_strobe(upd_strobe), .pulse_out(pulse_out), .upd_flag(upd_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_regs(input int c, input int a);
        @(negedge clk);
        cmp_val = W'(c); arl_val = W'(a); cmp_we = 1'b1; arl_we = 1'b1;
        @(negedge clk);
        cmp_we = 1'b0; arl_we = 1'b0;
    endtask

    task automatic rearm(input logic lvl);
        @(negedge clk);
        trig_in = lvl;
        repeat (4) @(negedge clk);
    endtask

    // Drive trig_in to lvl, then sample WIN cycles; k=1 is the sample after the starting edge.
    task automatic fire(input logic lvl, input int glitch_k, output int c1, output int c2,
                        output int nchg, output int lvl1, output int fk, output int nflag);
        logic prev;
        c1 = -1; c2 = -1; nchg = 0; lvl1 = -1; fk = -1; nflag = 0;
        @(negedge clk);
        prev = pulse_out;
        trig_in = lvl;
        for (int k = 1; k <= WIN; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (pulse_out != prev) begin
                nchg++;
                if (c1 < 0) begin c1 = k; lvl1 = int'(pulse_out); end
                else if (c2 < 0) c2 = k;
                prev = pulse_out;
            end
            if (upd_flag) begin
                nflag++;
                if (fk < 0) fk = k;
            end
            if (glitch_k > 0 && k == glitch_k)     trig_in = ~lvl;
            if (glitch_k > 0 && k == glitch_k + 1) trig_in = lvl;
        end
    endtask

    int c1, c2, nc, l1, fk, nf;

    task automatic t_reset();
        chk("R1 pulse_out in reset", int'(pulse_out), 0);
        chk("R1 upd_flag in reset", int'(upd_flag), 0);
    endtask

    task automatic t_basic();
        wr_regs(3, 7);
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R3 rise cycle", c1, 4);
        chk("R3 rise level", l1, 1);
        chk("R4 fall cycle", c2, 9);
        chk("R4 single pulse", nc, 2);
        chk("R6 flag cycle", fk, 9);
        chk("R6 flag count", nf, 1);
        rearm(1'b0);
        fire(1'b0, 0, c1, c2, nc, l1, fk, nf);
        chk("R2 falling edge ignored", nc, 0);
        chk("R2 no flag", nf, 0);
    endtask

    task automatic t_narrow();
        wr_regs(5, 5);
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R3 rise cmp=5", c1, 6);
        chk("R4 one-cycle width", c2, 7);
    endtask

    task automatic t_retrig();
        wr_regs(3, 7);
        rearm(1'b0);
        fire(1'b1, 3, c1, c2, nc, l1, fk, nf);
        chk("R5 rise unchanged", c1, 4);
        chk("R5 fall unchanged", c2, 9);
        chk("R5 no extra pulse", nc, 2);
        chk("R5 single flag", nf, 1);
    endtask

    task automatic t_fall_sel();
        rearm(1'b0);
        trig_fall = 1'b1;
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R2 rising ignored when falling selected", nc, 0);
        fire(1'b0, 0, c1, c2, nc, l1, fk, nf);
        chk("R2 falling start rise", c1, 4);
        chk("R2 falling start fall", c2, 9);
        trig_fall = 1'b0;
    endtask

    task automatic t_pwm1();
        mode = 3'b110;
        rearm(1'b0);
        chk("R7 PWM1 idle high", int'(pulse_out), 1);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R7 drop at compare", c1, 4);
        chk("R7 level after match", l1, 0);
        chk("R7 restore at wrap", c2, 9);
        mode = 3'b111;
    endtask

    task automatic t_fast();
        fast_en = 1'b1;
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R8 PWM2 fast rise", c1, 1);
        chk("R8 PWM2 fast level", l1, 1);
        chk("R8 PWM2 fast fall", c2, 9);
        mode = 3'b110;
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R8 PWM1 fast change", c1, 1);
        chk("R8 PWM1 fast level", l1, 0);
        chk("R8 PWM1 fast restore", c2, 9);
        mode = 3'b000;
        rearm(1'b0);
        chk("R9 idle low mode 000", int'(pulse_out), 0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R9 no output mode 000 with fast", nc, 0);
        chk("R9 counter still wraps", fk, 9);
        fast_en = 1'b0;
        mode = 3'b011;
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R9 no output mode 011", nc, 0);
        mode = 3'b111;
    endtask

    task automatic t_polarity();
        out_inv = 1'b1;
        rearm(1'b0);
        chk("R10 inverted idle", int'(pulse_out), 1);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R10 inverted active edge", c1, 4);
        chk("R10 inverted level", l1, 0);
        chk("R10 inverted end", c2, 9);
        out_inv = 1'b0;
    endtask

    task automatic t_preload();
        cmp_pre = 1'b1; arl_pre = 1'b1;
        wr_regs(2, 4);
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R11 shadow not active rise", c1, 4);
        chk("R11 shadow not active fall", c2, 9);
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R12 wrap loaded cmp", c1, 3);
        chk("R12 wrap loaded arl", c2, 6);
        wr_regs(4, 9);
        @(negedge clk);
        upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
        chk("R6 flag after strobe", int'(upd_flag), 1);
        @(negedge clk);
        chk("R6 flag one cycle", int'(upd_flag), 0);
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R11 strobe loaded cmp", c1, 5);
        chk("R11 strobe loaded arl", c2, 11);
        cmp_pre = 1'b0; arl_pre = 1'b0;
        wr_regs(1, 2);
        rearm(1'b0);
        fire(1'b1, 0, c1, c2, nc, l1, fk, nf);
        chk("R11 direct write cmp", c1, 2);
        chk("R11 direct write arl", c2, 4);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL all: watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_narrow();
        t_retrig();
        t_fall_sel();
        t_pwm1();
        t_fast();
        t_polarity();
        t_preload();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule